// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Status Flags and Interrupt

This block sits between the register interface of an SPI controller and its serial shift engine. It holds two byte queues. The CPU writes bytes into the transmit queue and the shift engine drains them. The shift engine deposits received bytes into the receive queue and the CPU drains them. Both read sides are first-word-fall-through: the oldest byte is presented on the data output before the pop strobe.

Around the queues the block keeps a set of registered status flags:
- room in the transmit queue;
- data waiting in the receive queue;
- a receive queue that has reached three quarters of its capacity and wants servicing;
- a receive queue that is completely full;
- a done indication that the transmit queue is drained and the shift engine has gone idle.

A single interrupt line is raised from the done flag and from the three-quarter flag, each gated by its own enable input. Two single-cycle clear strobes flush the queues. A strobe leaves no state behind, so it acts as a self-clearing command.

Top module: `spi_fifo_status`

## Requirements
- R1: Each queue stores up to 64 bytes (parameter `DEPTH`) and returns them in the order they were accepted. The oldest byte is visible on the read-data output while the queue is non-empty.
- R2: `st_tx_space` is 1 exactly when the transmit queue holds fewer than 64 bytes.
- R3: `st_rx_avail` is 1 exactly when the receive queue holds at least one byte.
- R4: `st_rx_need` is 1 exactly when the receive queue holds 48 or more bytes (three quarters of `DEPTH`).
- R5: `st_rx_full` is 1 exactly when the receive queue holds all 64 bytes. Whenever it is 1, `st_rx_need` is also 1.
- R6: `st_done` is 1 exactly when the transmit queue is empty and `eng_busy` was 0 at the last clock edge.
- R7: `irq` equals (`st_done` AND `irq_done_en`) OR (`st_rx_need` AND `irq_rx_en`). It follows the enables within the same cycle.
- R8: A one-cycle pulse on `clr_tx` or `clr_rx` empties that queue at the next edge. It takes priority over a push in the same cycle. It leaves nothing pending, so a push in a later cycle is accepted normally.
- R9: A push into a full queue is dropped and a pop from an empty queue is ignored. In both cases the queue's contents and level stay unchanged.
- R10: All five status flags are registered. They change only after the clock edge that applies a push, pop, clear or `eng_busy` change.
- R11: After reset both queues are empty: `st_tx_space`=1, `st_done`=1, `st_rx_avail`=0, `st_rx_need`=0, `st_rx_full`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tx_push | input | 1 | CPU writes one byte to the transmit queue |
| cpu_tx_data | input | 8 | Byte written by the CPU |
| cpu_rx_pop | input | 1 | CPU removes the oldest received byte |
| cpu_rx_data | output | 8 | Oldest byte of the receive queue |
| eng_tx_pop | input | 1 | Shift engine removes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest byte of the transmit queue |
| eng_rx_push | input | 1 | Shift engine deposits one received byte |
| eng_rx_data | input | 8 | Byte deposited by the shift engine |
| eng_busy | input | 1 | Shift engine is still shifting a byte |
| clr_tx | input | 1 | One-cycle flush of the transmit queue |
| clr_rx | input | 1 | One-cycle flush of the receive queue |
| irq_done_en | input | 1 | Enable interrupt on done |
| irq_rx_en | input | 1 | Enable interrupt on receive three-quarter level |
| st_tx_space | output | 1 | Transmit queue has a free slot |
| st_rx_avail | output | 1 | Receive queue is non-empty |
| st_rx_need | output | 1 | Receive queue at or above three quarters |
| st_rx_full | output | 1 | Receive queue full |
| st_done | output | 1 | Transmit queue empty and engine idle |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded properties guard, on every cycle, the invariants between neighbouring pieces of logic:
- levels never exceed the depth;
- a clear strobe always leaves an empty queue;
- a push to a full queue or a pop from an empty one leaves the level alone;
- a full receive queue always reports the three-quarter flag;
- done implies transmit space;
- the interrupt line agrees with the gated flags.

Byte ordering through each queue, the exact 47/48 and 63/64 thresholds, the one-cycle lag of the registered flags, the effect of the engine's busy signal on done, and the clear-beats-push rule are shown only by the bench's directed scenarios. There, a scoreboard queue compares every byte that leaves the block.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

   typedef struct packed {
      logic tx_space;
      logic rx_avail;
      logic rx_need;
      logic rx_full;
      logic done;
   } fifo_status_t;

   localparam fifo_status_t STATUS_RESET = '{tx_space: 1'b1, rx_avail: 1'b0,
                                             rx_need: 1'b0, rx_full: 1'b0,
                                             done: 1'b1};

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    level_nxt
);

   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("spi_byte_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_byte_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_inc, rd_ptr_inc;
   logic [CW-1:0]    level;
   logic             wr_ok, rd_ok;

   assign wr_ok = push && !clr && (level != FULL_LVL);
   assign rd_ok = pop  && !clr && (level != '0);

   // Pointer wrap: free-running for power-of-two depths, compared otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_ptr_inc = wr_ptr + 1'b1;
         assign rd_ptr_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_ptr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_comb begin
      if (clr) level_nxt = '0;
      else     level_nxt = level + CW'(wr_ok) - CW'(rd_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         level <= level_nxt;
         if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (wr_ok) wr_ptr <= wr_ptr_inc;
            if (rd_ok) rd_ptr <= rd_ptr_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wdata;
   end

   assign rdata = mem[rd_ptr];

   // R1: level never exceeds capacity
   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL);
   // R8: a clear strobe always leaves an empty queue
   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));
   // R9: push into a full queue is dropped
   p_full_push_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (level == FULL_LVL && push && !pop && !clr) |=> (level == FULL_LVL));
   // R9: pop from an empty queue is ignored
   p_empty_pop_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && pop && !push && !clr) |=> (level == '0));

endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
   import spi_fifo_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int RX_NEED_LVL = 48,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [CW-1:0] tx_lvl_nxt,
   input  logic [CW-1:0] rx_lvl_nxt,
   input  logic         eng_busy,
   output fifo_status_t st
);

   generate
      if (RX_NEED_LVL < 1 || RX_NEED_LVL > DEPTH) begin : g_bad_lvl
         $error("spi_fifo_flags: RX_NEED_LVL must lie in 1..DEPTH");
      end
   endgenerate

   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
   localparam logic [CW-1:0] NEED_LVL = CW'(RX_NEED_LVL);

   fifo_status_t st_nxt;

   always_comb begin
      st_nxt.tx_space = (tx_lvl_nxt != FULL_LVL);
      st_nxt.rx_avail = (rx_lvl_nxt != '0);
      st_nxt.rx_need  = (rx_lvl_nxt >= NEED_LVL);
      st_nxt.rx_full  = (rx_lvl_nxt == FULL_LVL);
      st_nxt.done     = (tx_lvl_nxt == '0) && !eng_busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= STATUS_RESET;
      else        st <= st_nxt;
   end

   // R5: a full receive queue always reports the service level
   p_full_has_need_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st.rx_full |-> st.rx_need);
   // R6: done means an empty transmit queue, so space is available
   p_done_has_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st.done |-> st.tx_space);
   // R4: service level implies data present
   p_need_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st.rx_need |-> st.rx_avail);

endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic rx_need,
   input  logic en_done,
   input  logic en_rx,
   output logic irq
);

   logic irq_raw;
   assign irq_raw = (done && en_done) || (rx_need && en_rx);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_raw;
         end
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
   import spi_fifo_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int WIDTH   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_tx_push,
   input  logic [WIDTH-1:0] cpu_tx_data,
   input  logic             cpu_rx_pop,
   output logic [WIDTH-1:0] cpu_rx_data,
   input  logic             eng_tx_pop,
   output logic [WIDTH-1:0] eng_tx_data,
   input  logic             eng_rx_push,
   input  logic [WIDTH-1:0] eng_rx_data,
   input  logic             eng_busy,
   input  logic             clr_tx,
   input  logic             clr_rx,
   input  logic             irq_done_en,
   input  logic             irq_rx_en,
   output logic             st_tx_space,
   output logic             st_rx_avail,
   output logic             st_rx_need,
   output logic             st_rx_full,
   output logic             st_done,
   output logic             irq
);

   localparam int CW          = $clog2(DEPTH + 1);
   localparam int RX_NEED_LVL = (DEPTH * 3) / 4;

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("spi_fifo_status: DEPTH must be at least 4");
      end
   endgenerate

   logic [CW-1:0] tx_lvl_nxt, rx_lvl_nxt;
   fifo_status_t  st;

   spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_tx),
      .push      (cpu_tx_push),
      .wdata     (cpu_tx_data),
      .pop       (eng_tx_pop),
      .rdata     (eng_tx_data),
      .level_nxt (tx_lvl_nxt)
   );

   spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_rx),
      .push      (eng_rx_push),
      .wdata     (eng_rx_data),
      .pop       (cpu_rx_pop),
      .rdata     (cpu_rx_data),
      .level_nxt (rx_lvl_nxt)
   );

   spi_fifo_flags #(.DEPTH(DEPTH), .RX_NEED_LVL(RX_NEED_LVL)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_lvl_nxt (tx_lvl_nxt),
      .rx_lvl_nxt (rx_lvl_nxt),
      .eng_busy   (eng_busy),
      .st         (st)
   );

   spi_irq_gen #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (st.done),
      .rx_need (st.rx_need),
      .en_done (irq_done_en),
      .en_rx   (irq_rx_en),
      .irq     (irq)
   );

   assign st_tx_space = st.tx_space;
   assign st_rx_avail = st.rx_avail;
   assign st_rx_need  = st.rx_need;
   assign st_rx_full  = st.rx_full;
   assign st_done     = st.done;

   generate
      if (!IRQ_REG) begin : g_irq_checks
         // R7: interrupt silent when no enabled source is active
         p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !((st.done && irq_done_en) || (st.rx_need && irq_rx_en)) |-> !irq);
         // R7: an enabled active source drives the line
         p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((st.done && irq_done_en) || (st.rx_need && irq_rx_en)) |-> irq);
      end
   endgenerate

endmodule

// File: tb/tb_spi_fifo_status.sv
module tb_spi_fifo_status;

   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_tx_push = 0, cpu_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
   logic [7:0] cpu_tx_data = '0, eng_rx_data = '0;
   logic [7:0] cpu_rx_data, eng_tx_data;
   logic       eng_busy = 0, clr_tx = 0, clr_rx = 0, irq_done_en = 0, irq_rx_en = 0;
   logic       st_tx_space, st_rx_avail, st_rx_need, st_rx_full, st_done, irq;

   int checks = 0, failures = 0;
   int txc = 0, rxc = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];

   always #10 clk = ~clk;   // 50 MHz

   spi_fifo_status dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_tx_push(cpu_tx_push), .cpu_tx_data(cpu_tx_data),
      .cpu_rx_pop(cpu_rx_pop), .cpu_rx_data(cpu_rx_data),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .eng_busy(eng_busy), .clr_tx(clr_tx), .clr_rx(clr_rx),
      .irq_done_en(irq_done_en), .irq_rx_en(irq_rx_en),
      .st_tx_space(st_tx_space), .st_rx_avail(st_rx_avail),
      .st_rx_need(st_rx_need), .st_rx_full(st_rx_full),
      .st_done(st_done), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected flags from the bench's own level model (called after an edge)
   task automatic check_flags(string tag);
      logic e_done, e_need;
      e_done = (txc == 0) && !eng_busy;
      e_need = (rxc >= 48);
      chk({tag, " R2 tx_space"}, st_tx_space, txc < DEPTH);
      chk({tag, " R3 rx_avail"}, st_rx_avail, rxc > 0);
      chk({tag, " R4 rx_need"},  st_rx_need,  e_need);
      chk({tag, " R5 rx_full"},  st_rx_full,  rxc == DEPTH);
      chk({tag, " R6 done"},     st_done,     e_done);
      chk({tag, " R7 irq"},      irq, (e_done && irq_done_en) || (e_need && irq_rx_en));
   endtask

   // Driver: CPU writes a byte, expectation queued
   task automatic cpu_push(logic [7:0] b);
      @(negedge clk);
      cpu_tx_push = 1; cpu_tx_data = b;
      @(negedge clk);
      cpu_tx_push = 0;
      if (txc < DEPTH) begin txq.push_back(b); txc++; end
   endtask

   // Monitor: engine takes a byte, compared against the scoreboard
   task automatic eng_pop(string tag);
      @(negedge clk);
      eng_tx_pop = 1;
      if (txc > 0) chk({tag, " R1 tx order"}, eng_tx_data, txq.pop_front());
      @(negedge clk);
      eng_tx_pop = 0;
      if (txc > 0) txc--;
   endtask

   task automatic eng_push(logic [7:0] b);
      @(negedge clk);
      eng_rx_push = 1; eng_rx_data = b;
      @(negedge clk);
      eng_rx_push = 0;
      if (rxc < DEPTH) begin rxq.push_back(b); rxc++; end
   endtask

   task automatic cpu_pop(string tag);
      @(negedge clk);
      cpu_rx_pop = 1;
      if (rxc > 0) chk({tag, " R1 rx order"}, cpu_rx_data, rxq.pop_front());
      @(negedge clk);
      cpu_rx_pop = 0;
      if (rxc > 0) rxc--;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_flags("R11 reset");

      // Basic transmit path with done
      cpu_push(8'hA1); cpu_push(8'hB2); cpu_push(8'hC3);
      check_flags("R6 tx loaded");
      eng_pop("R1 a"); eng_pop("R1 b"); eng_pop("R1 c");
      check_flags("R6 tx drained");

      // Engine busy holds done low; interrupt follows enables
      @(negedge clk); eng_busy = 1; irq_done_en = 1;
      @(negedge clk);
      check_flags("R6 busy");
      eng_busy = 0;
      @(negedge clk);
      check_flags("R7 done irq");
      irq_done_en = 0; #1;
      chk("R7 enable drop same cycle", irq, 0);

      // Fill transmit queue, overflow push dropped
      for (int i = 0; i < DEPTH; i++) cpu_push(8'(i + 16));
      check_flags("R2 tx full");
      cpu_push(8'hEE);
      check_flags("R9 tx overflow");
      for (int i = 0; i < DEPTH; i++) eng_pop("R9 drain");
      check_flags("R9 tx empty after drain");

      // Registered flag lag
      @(negedge clk);
      eng_rx_push = 1; eng_rx_data = 8'h55; #1;
      chk("R10 avail before edge", st_rx_avail, 0);
      @(negedge clk);
      eng_rx_push = 0; rxq.push_back(8'h55); rxc++;
      chk("R10 avail after edge", st_rx_avail, 1);

      // Receive thresholds
      irq_rx_en = 1;
      for (int i = 1; i < 47; i++) eng_push(8'(i * 3));
      check_flags("R4 level 47");
      eng_push(8'h48);
      check_flags("R4 level 48");
      for (int i = 48; i < 63; i++) eng_push(8'(i + 100));
      check_flags("R5 level 63");
      eng_push(8'h77);
      check_flags("R5 level 64");
      eng_push(8'h99);
      check_flags("R9 rx overflow");
      cpu_pop("R5 pop one");
      check_flags("R5 level 63 again");
      while (rxc > 0) cpu_pop("R1 rx drain");
      check_flags("R3 rx empty");
      irq_rx_en = 0;

      // Pop from empty ignored
      cpu_pop("R9 empty pop");
      check_flags("R9 empty pop");
      eng_push(8'h3C);
      cpu_pop("R9 after empty pop");

      // Clear receive queue, then fresh push accepted
      eng_push(8'h01); eng_push(8'h02); eng_push(8'h03);
      @(negedge clk); clr_rx = 1;
      @(negedge clk); clr_rx = 0; rxq.delete(); rxc = 0;
      check_flags("R8 rx cleared");
      eng_push(8'hD4);
      check_flags("R8 push after clear");
      cpu_pop("R8 fresh byte");

      // Clear transmit queue with a simultaneous push
      cpu_push(8'h11); cpu_push(8'h22);
      @(negedge clk); clr_tx = 1; cpu_tx_push = 1; cpu_tx_data = 8'h33;
      @(negedge clk); clr_tx = 0; cpu_tx_push = 0; txq.delete(); txc = 0;
      check_flags("R8 clear beats push");
      cpu_push(8'h44);
      eng_pop("R8 tx after clear");
      check_flags("R8 tx final");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule